// File: doc/BRIEF.md
# SPI Flash Region Access Checker

This block stands in front of an SPI flash controller and rules on each register-initiated flash access from one of three bus masters: the host processor (master code 0), the management engine (code 1) and the gigabit Ethernet controller (code 2). The flash is divided into five regions, each with a 13-bit base and limit in 4 KiB blocks. Region indices are 0 for the descriptor, 1 for BIOS, 2 for the management engine, 3 for gigabit Ethernet and 4 for platform data. Each master has a 32-bit permission word with three fields: read enables in bits 20:16, write enables in bits 28:24, and the 16-bit requestor ID it must present in bits 15:0.

A request strobe captures the master, direction, 25-bit flash linear address and requestor ID. One cycle later the block presents a registered verdict with four parts: grant or deny, the index of the matched region, an out-of-range flag and a deny reason. Two write protections outside the permission words also take part. One guards a BIOS address range and the other is a global protection from system management mode. If either is active, every write is refused.

Top module: `flash_region_guard`

## Requirements
- R1: Address bits 24:12 select a region when they lie between that region's base and limit, both ends included, so the whole limit block belongs to the region. When regions overlap, the lowest index wins. The matched index is reported on respRegion.
- R2: A region whose base exceeds its limit is unused and never matches (for example base 1FFFh, limit 0000h).
- R3: When no other rule decides, a read into region r is granted only if permission-word bit 16+r is set. A write into region r is granted only if bit 24+r is set.
- R4: Each master is always granted read and write access to its own region, whatever its permission bits hold. Master 0 owns region 1, master 1 owns region 2 and master 2 owns region 3.
- R5: reqId must equal bits 15:0 of the requesting master's permission word. Master code 3 never matches. A mismatch denies the access.
- R6: While biosRangeWp or smiGlobalWp is high, every write is denied, including writes to the master's own region. Reads are not affected.
- R7: An address in no active region is denied with respOutOfRange=1, respRegion=7 and reason 0.
- R8: A request presented with reqValid at a rising edge yields respValid=1 for exactly the following cycle, carrying that request's verdict.
- R9: Reason codes are 0 for granted or no reason, 1 for permission, 2 for requestor ID and 3 for write protect. When several apply, the ID check takes precedence over write protect, and write protect over permission. A grant always carries reason 0.
- R10: After reset: respValid=0, respGrant=0, respRegion=7, respOutOfRange=0, reason 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regionBase | input | 5x13 | Base block of each region |
| regionLimit | input | 5x13 | Inclusive limit block of each region |
| masterPerm | input | 3x32 | Permission word per master |
| biosRangeWp | input | 1 | BIOS range write protection active |
| smiGlobalWp | input | 1 | Global SMM write protection active |
| reqValid | input | 1 | Request strobe |
| reqMaster | input | 2 | Master code 0..2 |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 25 | Flash linear address |
| reqId | input | 16 | Requestor ID presented |
| respValid | output | 1 | Verdict valid this cycle |
| respGrant | output | 1 | Access allowed |
| respRegion | output | 3 | Matched region index, 7 when none |
| respOutOfRange | output | 1 | Address hit no active region |
| respReason | output | 2 | Deny reason code |

## Verification
The hardest cases to reach are the ones where rules conflict. Examples are an own-region write while a write protection is active, or an ID mismatch on a write that would also be blocked by protection. Any of these shows which rule takes precedence. The stimulus reaches them by rewriting permission words and protection inputs between requests: one pass zeroes the host's permission word so that only the ownership override can grant, and another gives a disabled region an overlapping range to test lowest-index priority. Accesses at the last byte of a limit block and the first byte after it check inclusive bounds.

// File: rtl/frg_pkg.sv
package frg_pkg;

  typedef enum logic [1:0] {
    DENY_NONE = 2'd0,
    DENY_PERM = 2'd1,
    DENY_ID   = 2'd2,
    DENY_WP   = 2'd3
  } denyReason_e;

  typedef struct packed {
    logic load;    // capture the verdict for the current request
    logic publish; // verdict is being presented this cycle
  } ctrlStrobes_t;

  // region owned by each master code
  localparam int OWN_OF_CPU = 1;
  localparam int OWN_OF_ME  = 2;
  localparam int OWN_OF_GBE = 3;

endpackage

// File: rtl/frg_region_match.sv
module frg_region_match #(
  parameter int FIELD_W   = 13,
  parameter int BLK_SHIFT = 12,
  parameter int ADDR_W    = FIELD_W + BLK_SHIFT
) (
  input  logic [FIELD_W-1:0] base,
  input  logic [FIELD_W-1:0] limit,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit
);

  logic [FIELD_W-1:0] blk;
  logic               active;

  assign blk    = addr[BLK_SHIFT +: FIELD_W];
  assign active = (base <= limit);
  assign hit    = active && (blk >= base) && (blk <= limit);

endmodule

// File: rtl/frg_control.sv
module frg_control
  import frg_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  output ctrlStrobes_t strobes,
  output logic         respValid
);

  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= reqValid;
  end

  always_comb begin
    strobes.load    = reqValid;
    strobes.publish = pending;
  end

  assign respValid = strobes.publish;

  // R8
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> respValid);

  // R8
  resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !respValid);

endmodule

// File: rtl/frg_datapath.sv
module frg_datapath
  import frg_pkg::*;
#(
  parameter int NUM_REGIONS = 5,
  parameter int NUM_MASTERS = 3,
  parameter int FIELD_W     = 13,
  parameter int BLK_SHIFT   = 12,
  parameter int ID_W        = 16,
  parameter int PERM_W      = 32,
  parameter int RD_LSB      = 16,
  parameter int WR_LSB      = 24,
  parameter int ADDR_W      = FIELD_W + BLK_SHIFT,
  parameter int MST_W       = 2,
  parameter int REG_IDX_W   = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  ctrlStrobes_t                        strobes,
  input  logic [NUM_REGIONS-1:0][FIELD_W-1:0] regionBase,
  input  logic [NUM_REGIONS-1:0][FIELD_W-1:0] regionLimit,
  input  logic [NUM_MASTERS-1:0][PERM_W-1:0]  masterPerm,
  input  logic                                biosRangeWp,
  input  logic                                smiGlobalWp,
  input  logic [MST_W-1:0]                    reqMaster,
  input  logic                                reqWrite,
  input  logic [ADDR_W-1:0]                   reqAddr,
  input  logic [ID_W-1:0]                     reqId,
  output logic                                respGrant,
  output logic [REG_IDX_W-1:0]                respRegion,
  output logic                                respOutOfRange,
  output logic [1:0]                          respReason
);

  localparam logic [REG_IDX_W-1:0] NO_REGION = '1;

  logic [NUM_REGIONS-1:0] hitVec;
  logic                   hitAny;
  logic [REG_IDX_W-1:0]   hitIdx;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    frg_region_match #(
      .FIELD_W  (FIELD_W),
      .BLK_SHIFT(BLK_SHIFT),
      .ADDR_W   (ADDR_W)
    ) u_match (
      .base (regionBase[r]),
      .limit(regionLimit[r]),
      .addr (reqAddr),
      .hit  (hitVec[r])
    );
  end

  // lowest index wins on overlap
  always_comb begin
    hitAny = 1'b0;
    hitIdx = NO_REGION;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (hitVec[r]) begin
        hitAny = 1'b1;
        hitIdx = REG_IDX_W'(r);
      end
    end
  end

  function automatic logic [REG_IDX_W-1:0] ownOf(input logic [MST_W-1:0] m);
    case (int'(m))
      0:       ownOf = REG_IDX_W'(OWN_OF_CPU);
      1:       ownOf = REG_IDX_W'(OWN_OF_ME);
      2:       ownOf = REG_IDX_W'(OWN_OF_GBE);
      default: ownOf = NO_REGION;
    endcase
  endfunction

  logic                   masterOk;
  logic [PERM_W-1:0]      selPerm;
  logic                   idOk;
  logic [NUM_REGIONS-1:0] enBits;
  logic [NUM_REGIONS-1:0] enShift;
  logic                   permBit;
  logic                   ownHit;
  logic                   wpBlock;

  always_comb begin
    selPerm = '0;
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (int'(reqMaster) == m) selPerm = masterPerm[m];
    end
  end

  assign masterOk = int'(reqMaster) < NUM_MASTERS;
  assign idOk     = masterOk && (reqId == selPerm[ID_W-1:0]);
  assign enBits   = reqWrite ? selPerm[WR_LSB +: NUM_REGIONS]
                             : selPerm[RD_LSB +: NUM_REGIONS];
  assign enShift  = enBits >> hitIdx;
  assign permBit  = hitAny && enShift[0];
  assign ownHit   = masterOk && hitAny && (ownOf(reqMaster) == hitIdx);
  assign wpBlock  = reqWrite && (biosRangeWp || smiGlobalWp);

  logic        nextGrant;
  logic        nextOor;
  denyReason_e nextReason;

  always_comb begin
    nextGrant  = 1'b0;
    nextOor    = 1'b0;
    nextReason = DENY_NONE;
    if (!hitAny) begin
      nextOor = 1'b1;
    end else if (!idOk) begin
      nextReason = DENY_ID;
    end else if (wpBlock) begin
      nextReason = DENY_WP;
    end else if (!(permBit || ownHit)) begin
      nextReason = DENY_PERM;
    end else begin
      nextGrant = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respGrant      <= 1'b0;
      respRegion     <= NO_REGION;
      respOutOfRange <= 1'b0;
      respReason     <= DENY_NONE;
    end else if (strobes.load) begin
      respGrant      <= nextGrant;
      respRegion     <= hitIdx;
      respOutOfRange <= nextOor;
      respReason     <= nextReason;
    end
  end

  // R7
  oor_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    respOutOfRange |-> (respRegion == NO_REGION) && !respGrant);

  // R9
  grant_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    respGrant |-> (respReason == DENY_NONE));

  // R6
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.load && reqWrite && (biosRangeWp || smiGlobalWp)) |=> !respGrant);

  // R5
  bad_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.load && !masterOk && hitAny) |=> (respReason == DENY_ID));

endmodule

// File: rtl/flash_region_guard.sv
module flash_region_guard
  import frg_pkg::*;
#(
  parameter int NUM_REGIONS = 5,
  parameter int NUM_MASTERS = 3,
  parameter int FIELD_W     = 13,
  parameter int BLK_SHIFT   = 12,
  parameter int ID_W        = 16,
  parameter int PERM_W      = 32,
  parameter int RD_LSB      = 16,
  parameter int WR_LSB      = 24,
  localparam int ADDR_W     = FIELD_W + BLK_SHIFT,
  localparam int MST_W      = $clog2(NUM_MASTERS + 1),
  localparam int REG_IDX_W  = $clog2(NUM_REGIONS + 1)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_REGIONS-1:0][FIELD_W-1:0] regionBase,
  input  logic [NUM_REGIONS-1:0][FIELD_W-1:0] regionLimit,
  input  logic [NUM_MASTERS-1:0][PERM_W-1:0]  masterPerm,
  input  logic                                biosRangeWp,
  input  logic                                smiGlobalWp,
  input  logic                                reqValid,
  input  logic [MST_W-1:0]                    reqMaster,
  input  logic                                reqWrite,
  input  logic [ADDR_W-1:0]                   reqAddr,
  input  logic [ID_W-1:0]                     reqId,
  output logic                                respValid,
  output logic                                respGrant,
  output logic [REG_IDX_W-1:0]                respRegion,
  output logic                                respOutOfRange,
  output logic [1:0]                          respReason
);

  ctrlStrobes_t strobes;

  frg_control u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .strobes  (strobes),
    .respValid(respValid)
  );

  frg_datapath #(
    .NUM_REGIONS(NUM_REGIONS),
    .NUM_MASTERS(NUM_MASTERS),
    .FIELD_W    (FIELD_W),
    .BLK_SHIFT  (BLK_SHIFT),
    .ID_W       (ID_W),
    .PERM_W     (PERM_W),
    .RD_LSB     (RD_LSB),
    .WR_LSB     (WR_LSB),
    .ADDR_W     (ADDR_W),
    .MST_W      (MST_W),
    .REG_IDX_W  (REG_IDX_W)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobes       (strobes),
    .regionBase    (regionBase),
    .regionLimit   (regionLimit),
    .masterPerm    (masterPerm),
    .biosRangeWp   (biosRangeWp),
    .smiGlobalWp   (smiGlobalWp),
    .reqMaster     (reqMaster),
    .reqWrite      (reqWrite),
    .reqAddr       (reqAddr),
    .reqId         (reqId),
    .respGrant     (respGrant),
    .respRegion    (respRegion),
    .respOutOfRange(respOutOfRange),
    .respReason    (respReason)
  );

endmodule

// File: tb/flash_region_guard_tb.sv
module flash_region_guard_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0][12:0] regionBase;
  logic [4:0][12:0] regionLimit;
  logic [2:0][31:0] masterPerm;
  logic        biosRangeWp = 1'b0;
  logic        smiGlobalWp = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqMaster = '0;
  logic        reqWrite = 1'b0;
  logic [24:0] reqAddr = '0;
  logic [15:0] reqId = '0;
  logic        respValid;
  logic        respGrant;
  logic [2:0]  respRegion;
  logic        respOutOfRange;
  logic [1:0]  respReason;

  flash_region_guard u_dut (
    .clk(clk), .rst_n(rst_n),
    .regionBase(regionBase), .regionLimit(regionLimit), .masterPerm(masterPerm),
    .biosRangeWp(biosRangeWp), .smiGlobalWp(smiGlobalWp),
    .reqValid(reqValid), .reqMaster(reqMaster), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqId(reqId),
    .respValid(respValid), .respGrant(respGrant), .respRegion(respRegion),
    .respOutOfRange(respOutOfRange), .respReason(respReason)
  );

  typedef struct {
    logic       g;
    logic [2:0] r;
    logic       o;
    logic [1:0] d;
    string      tag;
  } exp_t;

  exp_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // independent model of the requirements
  function automatic exp_t model(int m, bit w, logic [24:0] a, logic [15:0] id, string tag);
    exp_t e;
    int hit = -1;
    int own;
    logic [12:0] blk = a[24:12];
    for (int r = 0; r < 5; r++)
      if (hit < 0 && regionBase[r] <= regionLimit[r] && blk >= regionBase[r] && blk <= regionLimit[r])
        hit = r;
    e.tag = tag; e.g = 0; e.o = 0; e.d = 0; e.r = 3'd7;
    if (hit < 0) begin e.o = 1; return e; end
    e.r = 3'(hit);
    own = (m == 0) ? 1 : (m == 1) ? 2 : (m == 2) ? 3 : -1;
    if (m > 2 || id != masterPerm[m][15:0]) e.d = 2;
    else if (w && (biosRangeWp || smiGlobalWp)) e.d = 3;
    else if (hit != own && !masterPerm[m][(w ? 24 : 16) + hit]) e.d = 1;
    else e.g = 1;
    return e;
  endfunction

  task automatic send(int m, bit w, logic [24:0] a, logic [15:0] id, string tag);
    @(negedge clk);
    reqMaster = 2'(m); reqWrite = w; reqAddr = a; reqId = id; reqValid = 1'b1;
    expQ.push_back(model(m, w, a, id, tag));
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && respValid) begin
        exp_t e;
        compared++;
        if (expQ.size() == 0) begin
          mismatched++;
          $display("FAIL R8: unexpected respValid, actual 1 expected 0");
        end else begin
          e = expQ.pop_front();
          if (respGrant !== e.g || respRegion !== e.r || respOutOfRange !== e.o || respReason !== e.d) begin
            mismatched++;
            $display("FAIL %s: actual g=%0b r=%0d o=%0b d=%0d expected g=%0b r=%0d o=%0b d=%0d",
                     e.tag, respGrant, respRegion, respOutOfRange, respReason, e.g, e.r, e.o, e.d);
          end
        end
      end
    end
  end

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    compared++; mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    regionBase[0] = 13'h0000; regionLimit[0] = 13'h0000;
    regionBase[1] = 13'h0200; regionLimit[1] = 13'h03FF;
    regionBase[2] = 13'h0001; regionLimit[2] = 13'h01FF;
    regionBase[3] = 13'h0400; regionLimit[3] = 13'h0401;
    regionBase[4] = 13'h1FFF; regionLimit[4] = 13'h0000;
    masterPerm[0] = 32'h1A1B0000;
    masterPerm[1] = 32'h0C0D0000;
    masterPerm[2] = 32'h08080218;
    repeat (3) @(negedge clk);
    // R10 reset state
    compared++;
    if (respValid !== 0 || respGrant !== 0 || respRegion !== 3'd7 || respOutOfRange !== 0 || respReason !== 0) begin
      mismatched++;
      $display("FAIL R10: actual v=%0b g=%0b r=%0d o=%0b d=%0d expected 0 0 7 0 0",
               respValid, respGrant, respRegion, respOutOfRange, respReason);
    end
    rst_n = 1'b1;

    send(0, 0, 25'h0000010, 16'h0000, "R3 cpu read descriptor");
    send(0, 1, 25'h0000010, 16'h0000, "R3 cpu write descriptor");
    send(1, 1, 25'h0250000, 16'h0000, "R3 me write bios");
    send(1, 0, 25'h0001000, 16'h0000, "R4 me read own");
    send(2, 0, 25'h0000000, 16'h0218, "R3 gbe read descriptor");
    send(2, 1, 25'h0400800, 16'h0218, "R4 gbe write own");
    send(1, 1, 25'h0401FFF, 16'h0000, "R3 me write gbe");
    send(0, 0, 25'h03FFFFF, 16'h0000, "R1 limit block last byte");
    send(0, 0, 25'h0400000, 16'h0000, "R1 next block");
    send(0, 0, 25'h1FFF000, 16'h0000, "R2 R7 unused region");
    send(0, 0, 25'h0402000, 16'h0000, "R7 past last region");
    send(2, 0, 25'h0400000, 16'h0000, "R5 gbe bad id");
    send(3, 0, 25'h0200000, 16'h0000, "R5 master code 3");
    // back-to-back requests
    @(negedge clk);
    reqMaster = 0; reqWrite = 0; reqAddr = 25'h0300000; reqId = 0; reqValid = 1;
    expQ.push_back(model(0, 0, 25'h0300000, 0, "R8 back to back a"));
    @(negedge clk);
    reqMaster = 1; reqWrite = 0; reqAddr = 25'h0300000; reqId = 0;
    expQ.push_back(model(1, 0, 25'h0300000, 0, "R8 back to back b"));
    @(negedge clk);
    reqValid = 0;
    // write protections
    @(negedge clk); biosRangeWp = 1;
    send(0, 1, 25'h0200000, 16'h0000, "R6 bios wp own write");
    send(0, 0, 25'h0200000, 16'h0000, "R6 read under wp");
    send(2, 1, 25'h0400000, 16'h1111, "R9 id over wp");
    @(negedge clk); biosRangeWp = 0; smiGlobalWp = 1;
    send(1, 1, 25'h0001000, 16'h0000, "R6 smi wp");
    @(negedge clk); smiGlobalWp = 0;
    // only the ownership override grants now
    @(negedge clk); masterPerm[0] = 32'h00000000;
    send(0, 1, 25'h0200000, 16'h0000, "R4 override write");
    send(0, 0, 25'h0000000, 16'h0000, "R3 zeroed read descriptor");
    // overlap priority
    @(negedge clk); regionBase[4] = 13'h0200; regionLimit[4] = 13'h0200; masterPerm[0] = 32'h1A1B0000;
    send(0, 0, 25'h0200000, 16'h0000, "R1 overlap lowest index");
    send(0, 1, 25'h0000000, 16'h0000, "R9 perm reason");
    repeat (3) @(negedge clk);
    compared++;
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL R8: actual %0d pending expected 0", expQ.size());
    end
    summary();
  end

endmodule